// File: doc/BRIEF.md
# Persistence Waveform Raster Plotter

This block paints a four-channel waveform display into a frame of 8-bit pixels held in an external word-addressed memory. Each pixel byte carries a 3-bit colour field in its upper bits and a 5-bit intensity field in its lower bits. Each 32-bit memory word packs four horizontally adjacent pixels. The pixel at byte address A sits in word A/4, in lane A mod 4, and lane j occupies bits 8j+7:8j.

A single start pulse launches one frame pass, which runs three phases in strict order:
- **Fade.** Every word of the frame is read and written back one intensity step dimmer, so old traces decay over successive passes.
- **Plot.** One four-channel sample is taken per column. Each channel byte is drawn as one coloured point inside that channel's vertical band.
- **Marker.** A short white bar is drawn at the row that matches the trigger level latched at start.

A one-cycle done pulse then returns the block to idle. Scan-out of the frame to a display is handled elsewhere.

Top module: `trace_raster`

## Requirements
- R1: After reset the block is idle. done_o, smp_ready_o, mem_rd_en_o and mem_wr_en_o are all low, and they stay low until start_i is seen.
- R2: A start_i pulse in idle begins one frame pass and latches trig_lvl_i. A start_i pulse while a pass is running has no effect: no second pass follows.
- R3: The fade phase reads each of the H_PIX*V_LINES/4 words exactly once. Each word read in one cycle is written back to the same address in the next cycle, with all four byte enables set. In each byte the upper 3 bits are kept and the lower 5 bits drop by one, holding at zero. Every fade read happens before any plot or marker write.
- R4: smp_ready_o is high only in the plot phase while no sample is being drawn. A sample is taken when smp_valid_i and smp_ready_o are both high. Channel c is bits 8c+7:8c of smp_data_i. The n-th accepted sample (counting from 0) is drawn at column n, for n from 0 to H_PIX-1.
- R5: The row of a point is base(c) minus floor(value/2). base(3) is V_LINES, and each lower channel's base is BAND_STEP rows above the next higher one, so base(c) = V_LINES - BAND_STEP*(3-c).
- R6: Points are written at pixel byte address row*H_PIX+col, with exactly one byte enable set. The pixel colours are 0x1F for channel 0, 0xDF for channel 1, 0xBF for channel 2 and 0x5F for channel 3. Neighbouring pixels in the same word keep their values.
- R7: A point or marker row outside 0..V_LINES-1 is not written.
- R8: The marker sets MARK_PIX consecutive pixels to 0xFF. They lie on row MARK_BASE - floor(trig/2), starting at column MARK_COL. Other bytes of the words it touches keep their values.
- R9: done_o pulses for exactly one cycle after the last marker word. The block then returns to idle and makes no further memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame pass (taken only when idle) |
| trig_lvl_i | input | 8 | Trigger level, latched at start |
| smp_valid_i | input | 1 | Sample word valid |
| smp_data_i | input | 32 | Four 8-bit channel samples, channel c in bits 8c+7:8c |
| smp_ready_o | output | 1 | Block can take a sample this cycle |
| mem_rd_en_o | output | 1 | Memory read request; data returns the next cycle |
| mem_rd_addr_o | output | AW | Memory read word address |
| mem_rd_data_i | input | 32 | Memory read data, one cycle after the request |
| mem_wr_en_o | output | 1 | Memory write request |
| mem_wr_addr_o | output | AW | Memory write word address |
| mem_wr_data_o | output | 32 | Memory write data |
| mem_wr_be_o | output | 4 | Byte enables, bit j selects lane j |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench builds the block with a 16-column, 160-line frame, a band step of 40, the marker base at row 64, and an 8-pixel marker starting at column 5. This keeps the frame at 640 words, so several complete passes, each compared word by word against a model, fit in a short run.

The small geometry puts every band edge within reach of 8-bit samples:
- Channel 3 at its base row falls off the bottom of the frame.
- Channel 0 and channel 2 rise above the top.
- Large trigger levels push the marker off the frame.
- The marker start column is not word aligned, so its first and last words need partial byte masks.

// File: rtl/trace_raster_pkg.sv
package trace_raster_pkg;

    localparam int PIX_BITS = 8;
    localparam int LANES    = 4;
    localparam int CLR_BITS = 3;
    localparam int CH_NUM   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FADE,
        ST_PLOT,
        ST_MARK,
        ST_DONE
    } tr_state_e;

    localparam logic [PIX_BITS-1:0] TR_WHITE = 8'hFF;

    function automatic logic [PIX_BITS-1:0] tr_color(input logic [1:0] ch);
        case (ch)
            2'd0:    return 8'h1F;
            2'd1:    return 8'hDF;
            2'd2:    return 8'hBF;
            default: return 8'h5F;
        endcase
    endfunction

endpackage

// File: rtl/tr_word_fade.sv
module tr_word_fade
    import trace_raster_pkg::*;
(
    input  logic [LANES*PIX_BITS-1:0] word_i,
    output logic [LANES*PIX_BITS-1:0] word_o
);
    localparam int INT_BITS = PIX_BITS - CLR_BITS;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [CLR_BITS-1:0] hue;
        logic [INT_BITS-1:0] lvl;

        assign hue = word_i[j*PIX_BITS+INT_BITS +: CLR_BITS];
        assign lvl = word_i[j*PIX_BITS +: INT_BITS];

        // Intensity steps down by one and holds at zero; colour is untouched.
        assign word_o[j*PIX_BITS +: PIX_BITS] =
            {hue, (lvl == '0) ? lvl : lvl - INT_BITS'(1)};
    end
endmodule

// File: rtl/tr_point_map.sv
module tr_point_map #(
    parameter int H_PIX     = 640,
    parameter int V_LINES   = 480,
    parameter int BAND_STEP = 117,
    parameter int AW        = 17,
    parameter int COL_W     = 10
) (
    input  logic [1:0]       ch_i,
    input  logic [7:0]       val_i,
    input  logic [COL_W-1:0] col_i,
    output logic             hit_o,
    output logic [AW-1:0]    addr_o,
    output logic [3:0]       be_o
);
    int base_r;
    int row_r;
    int byte_r;

    always_comb begin
        base_r = V_LINES - BAND_STEP * (3 - int'(ch_i));
        row_r  = base_r - int'(val_i >> 1);
        byte_r = row_r * H_PIX + int'(col_i);
        hit_o  = (row_r >= 0) && (row_r < V_LINES);
        addr_o = AW'(byte_r >>> 2);
        be_o   = 4'b0001 << byte_r[1:0];
    end
endmodule

// File: rtl/tr_mark_map.sv
module tr_mark_map #(
    parameter int H_PIX     = 640,
    parameter int V_LINES   = 480,
    parameter int MARK_BASE = 128,
    parameter int MARK_COL  = 311,
    parameter int MARK_PIX  = 16,
    parameter int AW        = 17,
    parameter int KW        = 3
) (
    input  logic [7:0]    trig_i,
    input  logic [KW-1:0] k_i,
    output logic          hit_o,
    output logic [AW-1:0] addr_o,
    output logic [3:0]    be_o
);
    int row_r;
    int start_r;
    int off_r;

    always_comb begin
        row_r   = MARK_BASE - int'(trig_i >> 1);
        start_r = row_r * H_PIX + MARK_COL;
        off_r   = start_r & 3;
        for (int j = 0; j < 4; j++) begin
            be_o[j] = ((4 * int'(k_i) + j - off_r) >= 0) &&
                      ((4 * int'(k_i) + j - off_r) < MARK_PIX);
        end
        hit_o  = (row_r >= 0) && (row_r < V_LINES) && (be_o != 4'b0000);
        addr_o = AW'((start_r >>> 2) + int'(k_i));
    end
endmodule

// File: rtl/trace_raster.sv
module trace_raster
    import trace_raster_pkg::*;
#(
    parameter int H_PIX     = 640,
    parameter int V_LINES   = 480,
    parameter int BAND_STEP = 117,
    parameter int MARK_BASE = 128,
    parameter int MARK_COL  = 311,
    parameter int MARK_PIX  = 16,
    localparam int WORDS     = H_PIX * V_LINES / LANES,
    localparam int AW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [7:0]    trig_lvl_i,
    input  logic          smp_valid_i,
    input  logic [31:0]   smp_data_i,
    output logic          smp_ready_o,
    output logic          mem_rd_en_o,
    output logic [AW-1:0] mem_rd_addr_o,
    input  logic [31:0]   mem_rd_data_i,
    output logic          mem_wr_en_o,
    output logic [AW-1:0] mem_wr_addr_o,
    output logic [31:0]   mem_wr_data_o,
    output logic [3:0]    mem_wr_be_o,
    output logic          done_o
);
    localparam int COL_W      = $clog2(H_PIX);
    localparam int MARK_WORDS = (MARK_PIX + 3) / 4 + 1;
    localparam int KW         = $clog2(MARK_WORDS + 1);

    typedef struct packed {
        tr_state_e      st;
        logic [AW-1:0]  rd_addr;
        logic           rd_fin;
        logic           pend;
        logic [AW-1:0]  wb_addr;
        logic [COL_W-1:0] col;
        logic [1:0]     ch;
        logic           busy;
        logic [31:0]    smp;
        logic [7:0]     trig;
        logic [KW-1:0]  mk;
    } tr_regs_t;

    tr_regs_t q, d;

    logic [31:0]   faded;
    logic          pt_hit, mk_hit;
    logic [AW-1:0] pt_addr, mk_addr;
    logic [3:0]    pt_be, mk_be;

    tr_word_fade u_fade (
        .word_i (mem_rd_data_i),
        .word_o (faded)
    );

    tr_point_map #(
        .H_PIX(H_PIX), .V_LINES(V_LINES), .BAND_STEP(BAND_STEP),
        .AW(AW), .COL_W(COL_W)
    ) u_point (
        .ch_i   (q.ch),
        .val_i  (q.smp[{q.ch, 3'b000} +: 8]),
        .col_i  (q.col),
        .hit_o  (pt_hit),
        .addr_o (pt_addr),
        .be_o   (pt_be)
    );

    tr_mark_map #(
        .H_PIX(H_PIX), .V_LINES(V_LINES), .MARK_BASE(MARK_BASE),
        .MARK_COL(MARK_COL), .MARK_PIX(MARK_PIX), .AW(AW), .KW(KW)
    ) u_mark (
        .trig_i (q.trig),
        .k_i    (q.mk),
        .hit_o  (mk_hit),
        .addr_o (mk_addr),
        .be_o   (mk_be)
    );

    always_comb begin
        d             = q;
        smp_ready_o   = 1'b0;
        mem_rd_en_o   = 1'b0;
        mem_wr_en_o   = 1'b0;
        mem_wr_addr_o = '0;
        mem_wr_data_o = '0;
        mem_wr_be_o   = '0;
        done_o        = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_FADE;
                    d.rd_addr = '0;
                    d.rd_fin  = 1'b0;
                    d.pend    = 1'b0;
                    d.col     = '0;
                    d.busy    = 1'b0;
                    d.trig    = trig_lvl_i;
                end
            end
            ST_FADE: begin
                // Read word n while word n-1 is written back dimmed.
                if (!q.rd_fin) begin
                    mem_rd_en_o = 1'b1;
                    d.pend      = 1'b1;
                    d.wb_addr   = q.rd_addr;
                    if (q.rd_addr == AW'(WORDS - 1)) d.rd_fin = 1'b1;
                    else                             d.rd_addr = q.rd_addr + 1'b1;
                end else begin
                    d.pend = 1'b0;
                end
                if (q.pend) begin
                    mem_wr_en_o   = 1'b1;
                    mem_wr_addr_o = q.wb_addr;
                    mem_wr_data_o = faded;
                    mem_wr_be_o   = 4'hF;
                end
                if (q.rd_fin && q.pend) d.st = ST_PLOT;
            end
            ST_PLOT: begin
                smp_ready_o = !q.busy;
                if (!q.busy) begin
                    if (smp_valid_i) begin
                        d.smp  = smp_data_i;
                        d.busy = 1'b1;
                        d.ch   = 2'd3;
                    end
                end else begin
                    mem_wr_en_o   = pt_hit;
                    mem_wr_addr_o = pt_addr;
                    mem_wr_be_o   = pt_be;
                    mem_wr_data_o = {LANES{tr_color(q.ch)}};
                    if (q.ch == 2'd0) begin
                        d.busy = 1'b0;
                        if (q.col == COL_W'(H_PIX - 1)) begin
                            d.st = ST_MARK;
                            d.mk = '0;
                        end else begin
                            d.col = q.col + 1'b1;
                        end
                    end else begin
                        d.ch = q.ch - 2'd1;
                    end
                end
            end
            ST_MARK: begin
                mem_wr_en_o   = mk_hit;
                mem_wr_addr_o = mk_addr;
                mem_wr_be_o   = mk_be;
                mem_wr_data_o = {LANES{TR_WHITE}};
                if (q.mk == KW'(MARK_WORDS - 1)) d.st = ST_DONE;
                else                              d.mk = q.mk + 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    assign mem_rd_addr_o = q.rd_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/trace_raster_chk.sv
module trace_raster_chk #(
    parameter int H_PIX   = 640,
    parameter int V_LINES = 480,
    localparam int WORDS  = H_PIX * V_LINES / 4,
    localparam int AW     = $clog2(WORDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_ready_o,
    input logic          mem_rd_en_o,
    input logic [AW-1:0] mem_rd_addr_o,
    input logic          mem_wr_en_o,
    input logic [AW-1:0] mem_wr_addr_o,
    input logic [3:0]    mem_wr_be_o,
    input logic          done_o
);
    // R3
    fade_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> (mem_wr_en_o && mem_wr_be_o == 4'hF &&
                         mem_wr_addr_o == $past(mem_rd_addr_o)));

    // R4
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready_o |-> (!mem_rd_en_o && !mem_wr_en_o));

    // R7
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> (int'(mem_wr_addr_o) < WORDS && mem_wr_be_o != 4'h0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !mem_rd_en_o && !mem_wr_en_o && !smp_ready_o));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mem_rd_en_o && !mem_wr_en_o));
endmodule

bind trace_raster trace_raster_chk #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_chk (.*);

// File: tb/trace_raster_bench.sv
module trace_raster_bench;
    localparam int H_PIX     = 16;
    localparam int V_LINES   = 160;
    localparam int BAND_STEP = 40;
    localparam int MARK_BASE = 64;
    localparam int MARK_COL  = 5;
    localparam int MARK_PIX  = 8;
    localparam int WORDS     = H_PIX * V_LINES / 4;
    localparam int AW        = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    trig_lvl_i = '0;
    logic          smp_valid_i = 1'b0;
    logic [31:0]   smp_data_i = '0;
    logic          smp_ready_o;
    logic          mem_rd_en_o;
    logic [AW-1:0] mem_rd_addr_o;
    logic [31:0]   mem_rd_data_i;
    logic          mem_wr_en_o;
    logic [AW-1:0] mem_wr_addr_o;
    logic [31:0]   mem_wr_data_o;
    logic [3:0]    mem_wr_be_o;
    logic          done_o;

    always #2.5 clk = ~clk;

    trace_raster #(
        .H_PIX(H_PIX), .V_LINES(V_LINES), .BAND_STEP(BAND_STEP),
        .MARK_BASE(MARK_BASE), .MARK_COL(MARK_COL), .MARK_PIX(MARK_PIX)
    ) u_trace_raster (.*);

    // Memory model: one-cycle read, byte-masked write, bench preload port.
    logic [31:0] mem [WORDS];
    logic [31:0] exp_mem [WORDS];
    logic        clr_req = 1'b0;
    logic        pl_en = 1'b0;
    int          pl_addr = 0;
    logic [31:0] pl_data = '0;

    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (pl_en) begin
            mem[pl_addr] <= pl_data;
        end else begin
            if (mem_rd_en_o) mem_rd_data_i <= mem[mem_rd_addr_o];
            if (mem_wr_en_o)
                for (int j = 0; j < 4; j++)
                    if (mem_wr_be_o[j]) mem[mem_wr_addr_o][8*j +: 8] <= mem_wr_data_o[8*j +: 8];
        end
    end

    // Port monitor, sampled mid-cycle.
    int rd_cnt, wr_cnt, done_cnt;
    logic late_seen, order_bad;
    always @(negedge clk) begin
        if (mem_rd_en_o) begin
            rd_cnt++;
            if (late_seen) order_bad = 1'b1;
        end
        if (mem_wr_en_o) begin
            wr_cnt++;
            if (mem_wr_be_o != 4'hF) late_seen = 1'b1;
        end
        if (done_o) done_cnt++;
    end

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [7:0] read_px(input int row, input int col);
        int a;
        a = row * H_PIX + col;
        return mem[a / 4][8 * (a % 4) +: 8];
    endfunction

    function automatic logic [31:0] smp_word(input int pat, input int n);
        logic [7:0] b [4];
        for (int c = 0; c < 4; c++) begin
            case (pat)
                0: b[c] = 8'((n * 16 + c * 37) & 255);
                1: b[c] = (c == 3) ? 8'(n * 8 + 100) : (c == 2) ? 8'(200 - n) :
                          (c == 1) ? 8'(60 + n * 3) : 8'(20 + n);
                default: b[c] = (c == 3) ? 8'(n & 1) : (c == 2) ? 8'hFF :
                          (c == 1) ? 8'(10 * n) : 8'(255 - n);
            endcase
        end
        return {b[3], b[2], b[1], b[0]};
    endfunction

    function automatic void exp_set(input int row, input int col, input logic [7:0] v);
        int a;
        a = row * H_PIX + col;
        exp_mem[a / 4][8 * (a % 4) +: 8] = v;
    endfunction

    // Requirement-level model of one pass (R3, R5, R6, R7, R8).
    task automatic model_pass(input int pat, input logic [7:0] trig);
        logic [7:0] cols [4];
        cols[0] = 8'h1F; cols[1] = 8'hDF; cols[2] = 8'hBF; cols[3] = 8'h5F;
        for (int w = 0; w < WORDS; w++) begin
            exp_mem[w] = mem[w];
            for (int j = 0; j < 4; j++)
                if (exp_mem[w][8*j +: 5] != 5'd0) exp_mem[w][8*j +: 5] = exp_mem[w][8*j +: 5] - 5'd1;
        end
        for (int n = 0; n < H_PIX; n++) begin
            logic [31:0] s;
            s = smp_word(pat, n);
            for (int c = 3; c >= 0; c--) begin
                int row;
                row = (V_LINES - BAND_STEP * (3 - c)) - int'(s[8*c +: 8]) / 2;
                if (row >= 0 && row < V_LINES) exp_set(row, n, cols[c]);
            end
        end
        begin
            int mrow;
            mrow = MARK_BASE - int'(trig) / 2;
            if (mrow >= 0 && mrow < V_LINES)
                for (int p = 0; p < MARK_PIX; p++) exp_set(mrow, MARK_COL + p, 8'hFF);
        end
    endtask

    task automatic compare_image(input string req);
        int bad;
        bad = 0;
        for (int w = 0; w < WORDS; w++) begin
            if (mem[w] != exp_mem[w]) begin
                if (bad == 0)
                    $display("FAIL %s frame word %0d: actual %08h expected %08h", req, w, mem[w], exp_mem[w]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    // One complete pass: gap inserts idle cycles between samples,
    // extra_start pulses start_i in the middle of plotting.
    task automatic run_pass(input int pat, input logic [7:0] trig, input bit gap, input bit extra_start);
        int guard;
        model_pass(pat, trig);
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; late_seen = 1'b0; order_bad = 1'b0;
        @(negedge clk);
        trig_lvl_i = trig;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        trig_lvl_i = ~trig;
        for (int n = 0; n < H_PIX; n++) begin
            guard = 0;
            smp_data_i  = smp_word(pat, n);
            smp_valid_i = 1'b1;
            start_i     = extra_start && (n == 5);
            while (!smp_ready_o && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            if (guard >= 5000) begin
                check("R4", "sample accepted", 0, 1);
                break;
            end
            @(negedge clk);
            smp_valid_i = 1'b0;
            start_i     = 1'b0;
            smp_data_i  = 32'hA5A5_A5A5;
            if (gap) repeat (3) @(negedge clk);
        end
        smp_valid_i = 1'b0;
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        clr_req = 1'b1;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        clr_req = 1'b0;
        rst_n   = 1'b1;
        repeat (6) @(negedge clk);
        check("R1", "done_o idle", done_o, 0);
        check("R1", "smp_ready_o idle", smp_ready_o, 0);
        check("R1", "mem_rd_en_o idle", mem_rd_en_o, 0);
        check("R1", "mem_wr_en_o idle", mem_wr_en_o, 0);
    endtask

    task automatic t_ramp_pass();
        run_pass(0, 8'h20, 1'b0, 1'b0);
        compare_image("R3 R5 R6 R8");
        check("R3", "fade reads", rd_cnt, WORDS);
        check("R3", "fade before plot", order_bad, 0);
        check("R9", "done pulse cycles", done_cnt, 1);
        check("R5", "ch1 n=3 at row 38", read_px(38, 3), 8'hDF);
        check("R6", "ch3 n=0 at row 105", read_px(105, 0), 8'h5F);
        check("R8", "marker first pixel", read_px(48, 5), 8'hFF);
        check("R8", "marker last pixel", read_px(48, 12), 8'hFF);
        check("R8", "right of marker", read_px(48, 13), 8'h00);
        check("R8", "left of marker", read_px(48, 4), 8'h00);
    endtask

    task automatic t_fade_saturate();
        @(negedge clk);
        pl_en = 1'b1; pl_addr = 0; pl_data = 32'hFFE0_0100;
        @(negedge clk);
        pl_en = 1'b0;
        run_pass(1, 8'h60, 1'b0, 1'b0);
        compare_image("R3 R4");
        check("R3", "saturating fade word 0", mem[0], 32'hFEE0_0000);
        check("R3", "fade reads", rd_cnt, WORDS);
    endtask

    task automatic t_clip();
        run_pass(2, 8'd200, 1'b0, 1'b0);
        compare_image("R7");
        check("R7", "writes with clipped points and marker", wr_cnt, WORDS + 16);
    endtask

    task automatic t_busy_start();
        run_pass(0, 8'h10, 1'b1, 1'b1);
        compare_image("R2 R4");
        check("R2", "no second pass reads", rd_cnt, WORDS);
        check("R9", "single done", done_cnt, 1);
    endtask

    initial begin
        t_reset();
        t_ramp_pass();
        t_fade_saturate();
        t_clip();
        t_busy_start();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule